// File: doc/BRIEF.md
# Register-Immediate Integer Execution Unit

This unit is the integer execute stage of a three-format RISC core. Each cycle it takes one decoded instruction: the primary opcode, the function code, the shift-amount field, the 16-bit immediate, the two source register values and the two candidate destination indices. It covers addition and subtraction in trapping and wrapping forms, the four bitwise operations, shifts by a constant or by a register, signed and unsigned set-on-less-than, and the immediate forms including load-upper.

The outputs are registered. They are the result, the destination index, a write enable for the register file, an overflow-trap flag for the exception logic and an illegal-instruction flag. Decoding depends on the instruction. The immediate is sign- or zero-extended depending on the opcode. The destination comes from the `rd` field for register-register forms and from the `rt` field for immediate forms. A trapping overflow blocks the register write.

Top module: `exu_core`

## Requirements
- R1: With opcode 0, function codes 0x20 (add), 0x21 (addu), 0x22 (sub) and 0x23 (subu) give rs+rt or rs-rt modulo 2^32.
- R2: With opcode 0, function codes 0x24, 0x25, 0x26 and 0x27 give rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt).
- R3: Signed overflow on add (0x20), sub (0x22) or addi (opcode 0x08) raises the overflow trap and holds write enable low. addu, subu and addiu (opcode 0x09) never raise the trap and write the wrapped sum.
- R4: With opcode 0, function codes 0 (left logical), 2 (right logical) and 3 (right arithmetic) shift rt by the 5-bit shift field. Logical shifts fill with zero and the arithmetic shift fills with rt bit 31.
- R5: Function codes 4, 6 and 7 perform the same three shifts on rt, with the amount taken from rs bits 4:0.
- R6: Set-on-less-than gives 1 or 0. Function 0x2A and opcode 0x0A compare as signed; function 0x2B and opcode 0x0B compare as unsigned. For example, 1 < 0xFFFFFFFF gives 0 signed and 1 unsigned.
- R7: Opcodes 0x08, 0x09, 0x0A and 0x0B sign-extend the immediate. Opcodes 0x0C (and), 0x0D (or) and 0x0E (xor) zero-extend it.
- R8: Opcode 0x0F puts the immediate in result bits 31:16 and zero in bits 15:0.
- R9: The destination index is rd for opcode 0 and rt for all other opcodes. A destination index of 0 forces write enable low.
- R10: An unknown opcode, or an unknown function code under opcode 0, gives a result of 0, write enable low, no trap, and the illegal flag high.
- R11: While reset is low all outputs are zero. Otherwise every output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function code (opcode 0) |
| shamt_i | input | 5 | Constant shift amount field |
| imm_i | input | 16 | Immediate field |
| rs_val_i | input | 32 | First source operand value |
| rt_val_i | input | 32 | Second source operand value |
| rd_idx_i | input | 5 | rd destination index |
| rt_idx_i | input | 5 | rt destination index |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Register-file write enable |
| wr_idx_o | output | 5 | Selected destination index |
| ovf_trap_o | output | 1 | Signed-overflow trap |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
All five outputs come out of one register stage, so every instruction's result, enable, index and flags are due at the first rising edge after it is presented. The bench changes inputs on a falling edge and compares all outputs against its behavioural model on the next falling edge, half a cycle after the capturing edge. One extra check samples just after new inputs arrive and confirms that the outputs still hold the previous instruction's values before that edge.

// File: rtl/exu_pkg.sv
package exu_pkg;
  parameter int XLEN   = 32;
  parameter int IMM_W  = 16;
  parameter int OP_W   = 6;
  parameter int FN_W   = 6;
  parameter int REG_AW = 5;
  parameter int SH_W   = $clog2(XLEN);

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_ADDIU = 6'h09;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'h0a;
  localparam logic [OP_W-1:0] OP_SLTIU = 6'h0b;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0c;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0d;
  localparam logic [OP_W-1:0] OP_XORI  = 6'h0e;
  localparam logic [OP_W-1:0] OP_LUI   = 6'h0f;

  localparam logic [FN_W-1:0] F_SLL  = 6'h00;
  localparam logic [FN_W-1:0] F_SRL  = 6'h02;
  localparam logic [FN_W-1:0] F_SRA  = 6'h03;
  localparam logic [FN_W-1:0] F_SLLV = 6'h04;
  localparam logic [FN_W-1:0] F_SRLV = 6'h06;
  localparam logic [FN_W-1:0] F_SRAV = 6'h07;
  localparam logic [FN_W-1:0] F_ADD  = 6'h20;
  localparam logic [FN_W-1:0] F_ADDU = 6'h21;
  localparam logic [FN_W-1:0] F_SUB  = 6'h22;
  localparam logic [FN_W-1:0] F_SUBU = 6'h23;
  localparam logic [FN_W-1:0] F_AND  = 6'h24;
  localparam logic [FN_W-1:0] F_OR   = 6'h25;
  localparam logic [FN_W-1:0] F_XOR  = 6'h26;
  localparam logic [FN_W-1:0] F_NOR  = 6'h27;
  localparam logic [FN_W-1:0] F_SLT  = 6'h2a;
  localparam logic [FN_W-1:0] F_SLTU = 6'h2b;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOR,
    FN_SLT, FN_SLTU, FN_SLL, FN_SRL, FN_SRA, FN_LUI
  } fn_e;

  typedef struct packed {
    logic legal;
    fn_e  fn;
    logic use_imm;
    logic imm_sext;
    logic var_amt;
    logic trap_en;
    logic dst_rd;
  } ctrl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] funct_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o       = '0;
    ctrl_o.fn    = FN_ADD;
    ctrl_o.legal = 1'b1;
    if (op_i == OP_RTYPE) begin
      ctrl_o.dst_rd = 1'b1;
      unique case (funct_i)
        F_ADD:  begin ctrl_o.fn = FN_ADD; ctrl_o.trap_en = 1'b1; end
        F_ADDU: ctrl_o.fn = FN_ADD;
        F_SUB:  begin ctrl_o.fn = FN_SUB; ctrl_o.trap_en = 1'b1; end
        F_SUBU: ctrl_o.fn = FN_SUB;
        F_AND:  ctrl_o.fn = FN_AND;
        F_OR:   ctrl_o.fn = FN_OR;
        F_XOR:  ctrl_o.fn = FN_XOR;
        F_NOR:  ctrl_o.fn = FN_NOR;
        F_SLT:  ctrl_o.fn = FN_SLT;
        F_SLTU: ctrl_o.fn = FN_SLTU;
        F_SLL:  ctrl_o.fn = FN_SLL;
        F_SRL:  ctrl_o.fn = FN_SRL;
        F_SRA:  ctrl_o.fn = FN_SRA;
        F_SLLV: begin ctrl_o.fn = FN_SLL; ctrl_o.var_amt = 1'b1; end
        F_SRLV: begin ctrl_o.fn = FN_SRL; ctrl_o.var_amt = 1'b1; end
        F_SRAV: begin ctrl_o.fn = FN_SRA; ctrl_o.var_amt = 1'b1; end
        default: ctrl_o.legal = 1'b0;
      endcase
    end else begin
      ctrl_o.use_imm = 1'b1;
      unique case (op_i)
        OP_ADDI:  begin ctrl_o.fn = FN_ADD; ctrl_o.imm_sext = 1'b1; ctrl_o.trap_en = 1'b1; end
        OP_ADDIU: begin ctrl_o.fn = FN_ADD;  ctrl_o.imm_sext = 1'b1; end
        OP_SLTI:  begin ctrl_o.fn = FN_SLT;  ctrl_o.imm_sext = 1'b1; end
        OP_SLTIU: begin ctrl_o.fn = FN_SLTU; ctrl_o.imm_sext = 1'b1; end
        OP_ANDI:  ctrl_o.fn = FN_AND;
        OP_ORI:   ctrl_o.fn = FN_OR;
        OP_XORI:  ctrl_o.fn = FN_XOR;
        OP_LUI:   ctrl_o.fn = FN_LUI;
        default:  ctrl_o.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_x;
  logic [W:0]   full;

  assign b_x   = b_i ^ {W{sub_i}};
  assign full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];
  // signed overflow: equal operand signs, different result sign
  assign ovf_o  = (a_i[W-1] == b_x[W-1]) && (sum_o[W-1] != a_i[W-1]);
  assign lt_s_o = sum_o[W-1] ^ ovf_o;
  assign lt_u_o = ~full[W];
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] stg [AW+1];
  logic         fill;

  assign fill = arith_i & ~left_i & data_i[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[AW][W-1-i];
  end

  assign stg[0] = left_i ? rev_in : data_i;

  // log-depth right shifter; left shifts run through bit reversal
  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 2 ** k;
    assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  assign data_o = left_i ? rev_out : stg[AW];
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [FN_W-1:0]   funct_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [REG_AW-1:0] rd_idx_i,
  input  logic [REG_AW-1:0] rt_idx_i,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_idx_o,
  output logic              ovf_trap_o,
  output logic              illegal_o
);
  localparam int PAD_W = XLEN - IMM_W;

  ctrl_t             ctrl;
  logic [XLEN-1:0]   imm_x, opnd_b, sum, sh_out, res_d;
  logic [SH_W-1:0]   amt;
  logic              sub, ovf, lt_s, lt_u, trap_d, we_d;
  logic [REG_AW-1:0] dst_d;

  exu_decode u_dec (
    .op_i    (op_i),
    .funct_i (funct_i),
    .ctrl_o  (ctrl)
  );

  assign imm_x  = ctrl.imm_sext ? {{PAD_W{imm_i[IMM_W-1]}}, imm_i} : {{PAD_W{1'b0}}, imm_i};
  assign opnd_b = ctrl.use_imm ? imm_x : rt_val_i;
  assign sub    = (ctrl.fn == FN_SUB) || (ctrl.fn == FN_SLT) || (ctrl.fn == FN_SLTU);

  exu_addsub #(.W(XLEN)) u_add (
    .a_i    (rs_val_i),
    .b_i    (opnd_b),
    .sub_i  (sub),
    .sum_o  (sum),
    .ovf_o  (ovf),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  assign amt = ctrl.var_amt ? rs_val_i[SH_W-1:0] : shamt_i;

  exu_shift #(.W(XLEN), .AW(SH_W)) u_sh (
    .data_i  (rt_val_i),
    .amt_i   (amt),
    .left_i  (ctrl.fn == FN_SLL),
    .arith_i (ctrl.fn == FN_SRA),
    .data_o  (sh_out)
  );

  always_comb begin
    unique case (ctrl.fn)
      FN_ADD, FN_SUB: res_d = sum;
      FN_AND:  res_d = rs_val_i & opnd_b;
      FN_OR:   res_d = rs_val_i | opnd_b;
      FN_XOR:  res_d = rs_val_i ^ opnd_b;
      FN_NOR:  res_d = ~(rs_val_i | opnd_b);
      FN_SLT:  res_d = {{(XLEN-1){1'b0}}, lt_s};
      FN_SLTU: res_d = {{(XLEN-1){1'b0}}, lt_u};
      FN_SLL, FN_SRL, FN_SRA: res_d = sh_out;
      FN_LUI:  res_d = {imm_i, {PAD_W{1'b0}}};
      default: res_d = '0;
    endcase
    if (!ctrl.legal) res_d = '0;
  end

  assign dst_d  = ctrl.dst_rd ? rd_idx_i : rt_idx_i;
  assign trap_d = ctrl.legal & ctrl.trap_en & ovf;
  assign we_d   = ctrl.legal & ~trap_d & (dst_d != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      ovf_trap_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      result_o   <= res_d;
      wr_en_o    <= we_d;
      wr_idx_o   <= dst_d;
      ovf_trap_o <= trap_d;
      illegal_o  <= ~ctrl.legal;
    end
  end
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk
  import exu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [FN_W-1:0]   funct_i,
  input logic [REG_AW-1:0] rd_idx_i,
  input logic [REG_AW-1:0] rt_idx_i,
  input logic [XLEN-1:0]   result_o,
  input logic              wr_en_o,
  input logic [REG_AW-1:0] wr_idx_o,
  input logic              ovf_trap_o,
  input logic              illegal_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_trap_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap_o |-> !wr_en_o);

  p_unsigned_no_trap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) == OP_ADDIU ||
     ($past(op_i) == OP_RTYPE && ($past(funct_i) == F_ADDU || $past(funct_i) == F_SUBU)))
    |-> !ovf_trap_o);

  p_slt_bool_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) == OP_SLTI || $past(op_i) == OP_SLTIU ||
     ($past(op_i) == OP_RTYPE && ($past(funct_i) == F_SLT || $past(funct_i) == F_SLTU)))
    |-> result_o[XLEN-1:1] == '0);

  p_lui_low_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) == OP_LUI) |-> (result_o[IMM_W-1:0] == '0 && !illegal_o));

  p_dst_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) == OP_RTYPE) |-> wr_idx_o == $past(rd_idx_i));

  p_dst_rt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) != OP_RTYPE) |-> wr_idx_o == $past(rt_idx_i));

  p_zero_dst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_idx_o != '0);

  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0 && !wr_en_o && !ovf_trap_o));
endmodule

bind exu_core exu_core_chk u_chk (.*);

// File: tb/sim_exu_core.sv
`timescale 1ns/1ps
module sim_exu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op = '0, fn = '0;
  logic [4:0]  sh = '0, rd = '0, rt = '0;
  logic [15:0] imm = '0;
  logic [31:0] rs_v = '0, rt_v = '0;
  logic [31:0] res;
  logic        we, trap, ill;
  logic [4:0]  widx;

  logic [31:0] e_res;
  logic        e_we, e_trap, e_ill;
  logic [4:0]  e_idx;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  exu_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .funct_i(fn), .shamt_i(sh),
    .imm_i(imm), .rs_val_i(rs_v), .rt_val_i(rt_v), .rd_idx_i(rd), .rt_idx_i(rt),
    .result_o(res), .wr_en_o(we), .wr_idx_o(widx), .ovf_trap_o(trap), .illegal_o(ill)
  );

  task automatic model();
    logic [31:0] a, b, si, zi;
    longint s;
    logic ok;
    a = rs_v; b = rt_v; ok = 1'b1;
    si = {{16{imm[15]}}, imm};
    zi = {16'h0, imm};
    e_res = '0; e_trap = 1'b0;
    e_idx = (op == 6'h00) ? rd : rt;
    if (op == 6'h00) begin
      case (fn)
        6'h20: begin e_res = a + b; s = longint'($signed(a)) + longint'($signed(b));
                     e_trap = (s != longint'($signed(e_res))); end
        6'h21: e_res = a + b;
        6'h22: begin e_res = a - b; s = longint'($signed(a)) - longint'($signed(b));
                     e_trap = (s != longint'($signed(e_res))); end
        6'h23: e_res = a - b;
        6'h24: e_res = a & b;
        6'h25: e_res = a | b;
        6'h26: e_res = a ^ b;
        6'h27: e_res = ~(a | b);
        6'h2a: e_res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2b: e_res = (a < b) ? 32'd1 : 32'd0;
        6'h00: e_res = b << sh;
        6'h02: e_res = b >> sh;
        6'h03: e_res = $signed(b) >>> sh;
        6'h04: e_res = b << a[4:0];
        6'h06: e_res = b >> a[4:0];
        6'h07: e_res = $signed(b) >>> a[4:0];
        default: ok = 1'b0;
      endcase
    end else begin
      case (op)
        6'h08: begin e_res = a + si; s = longint'($signed(a)) + longint'($signed(si));
                     e_trap = (s != longint'($signed(e_res))); end
        6'h09: e_res = a + si;
        6'h0a: e_res = ($signed(a) < $signed(si)) ? 32'd1 : 32'd0;
        6'h0b: e_res = (a < si) ? 32'd1 : 32'd0;
        6'h0c: e_res = a & zi;
        6'h0d: e_res = a | zi;
        6'h0e: e_res = a ^ zi;
        6'h0f: e_res = {imm, 16'h0};
        default: ok = 1'b0;
      endcase
    end
    if (!ok) begin e_res = '0; e_trap = 1'b0; end
    e_ill = !ok;
    e_we  = ok && !e_trap && (e_idx != 5'd0);
  endtask

  task automatic compare(string tag);
    n_run++;
    if (res !== e_res || we !== e_we || widx !== e_idx || trap !== e_trap || ill !== e_ill) begin
      n_fail++;
      $display("FAIL %s op=%h fn=%h: got res=%h we=%b idx=%0d trap=%b ill=%b exp res=%h we=%b idx=%0d trap=%b ill=%b",
               tag, op, fn, res, we, widx, trap, ill, e_res, e_we, e_idx, e_trap, e_ill);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [5:0] f, input logic [4:0] s,
                       input logic [15:0] im, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] d, input logic [4:0] t, input string tag);
    @(negedge clk);
    op = o; fn = f; sh = s; imm = im; rs_v = a; rt_v = b; rd = d; rt = t;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string tag_of(logic [5:0] o, logic [5:0] f);
    if (o == 6'h00) begin
      if (f >= 6'h20 && f <= 6'h23) return "R1";
      if (f >= 6'h24 && f <= 6'h27) return "R2";
      if (f == 6'h00 || f == 6'h02 || f == 6'h03) return "R4";
      if (f == 6'h04 || f == 6'h06 || f == 6'h07) return "R5";
      if (f == 6'h2a || f == 6'h2b) return "R6";
      return "R10";
    end
    if (o == 6'h0a || o == 6'h0b) return "R6";
    if (o >= 6'h08 && o <= 6'h0e) return "R7";
    if (o == 6'h0f) return "R8";
    return "R10";
  endfunction

  initial begin
    logic [5:0] fns [16] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
                             6'h2a, 6'h2b, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
    // R11: reset state
    repeat (2) @(negedge clk);
    op = 6'h00; fn = 6'h20; rs_v = 32'd3; rt_v = 32'd4; rd = 5'd7;
    @(negedge clk);
    e_res = '0; e_we = 0; e_idx = '0; e_trap = 0; e_ill = 0;
    compare("R11");
    rst_n = 1'b1;

    // R1
    apply(6'h00, 6'h20, 0, 0, 32'd5, 32'd7, 5'd8, 5'd1, "R1");
    apply(6'h00, 6'h22, 0, 0, 32'd5, 32'd7, 5'd8, 5'd1, "R1");
    apply(6'h00, 6'h21, 0, 0, 32'hffff_ffff, 32'd2, 5'd9, 5'd1, "R1");
    apply(6'h00, 6'h23, 0, 0, 32'd0, 32'd1, 5'd9, 5'd1, "R1");
    // R2
    apply(6'h00, 6'h24, 0, 0, 32'habcd_1234, 32'hffff_0000, 5'd16, 5'd2, "R2");
    apply(6'h00, 6'h25, 0, 0, 32'habcd_1234, 32'hffff_0000, 5'd16, 5'd2, "R2");
    apply(6'h00, 6'h26, 0, 0, 32'habcd_1234, 32'hffff_0000, 5'd16, 5'd2, "R2");
    apply(6'h00, 6'h27, 0, 0, 32'habcd_1234, 32'hffff_0000, 5'd16, 5'd2, "R2");
    // R3
    apply(6'h00, 6'h20, 0, 0, 32'h7fff_ffff, 32'd1, 5'd10, 5'd3, "R3");
    apply(6'h00, 6'h21, 0, 0, 32'h7fff_ffff, 32'd1, 5'd10, 5'd3, "R3");
    apply(6'h00, 6'h22, 0, 0, 32'h8000_0000, 32'd1, 5'd10, 5'd3, "R3");
    apply(6'h00, 6'h23, 0, 0, 32'h8000_0000, 32'd1, 5'd10, 5'd3, "R3");
    apply(6'h08, 6'h00, 0, 16'h0001, 32'h7fff_ffff, 0, 5'd0, 5'd11, "R3");
    apply(6'h09, 6'h00, 0, 16'h0001, 32'h7fff_ffff, 0, 5'd0, 5'd11, "R3");
    // R4
    apply(6'h00, 6'h00, 5'd8, 0, 0, 32'habcd_1234, 5'd17, 5'd2, "R4");
    apply(6'h00, 6'h03, 5'd4, 0, 0, 32'habcd_1234, 5'd17, 5'd2, "R4");
    apply(6'h00, 6'h02, 5'd4, 0, 0, 32'habcd_1234, 5'd17, 5'd2, "R4");
    apply(6'h00, 6'h03, 5'd31, 0, 0, 32'h4000_0000, 5'd17, 5'd2, "R4");
    // R5
    apply(6'h00, 6'h06, 5'd3, 0, 32'd16, 32'habcd_1234, 5'd17, 5'd2, "R5");
    apply(6'h00, 6'h04, 5'd0, 0, 32'h25, 32'h0000_0001, 5'd17, 5'd2, "R5");
    apply(6'h00, 6'h07, 5'd0, 0, 32'hffff_ffe8, 32'h8000_0000, 5'd17, 5'd2, "R5");
    // R6
    apply(6'h00, 6'h2a, 0, 0, 32'd1, 32'hffff_ffff, 5'd8, 5'd2, "R6");
    apply(6'h00, 6'h2b, 0, 0, 32'd1, 32'hffff_ffff, 5'd8, 5'd2, "R6");
    apply(6'h0a, 6'h00, 0, 16'hffff, 32'hffff_fffe, 0, 5'd0, 5'd4, "R6");
    apply(6'h0b, 6'h00, 0, 16'hffff, 32'd5, 0, 5'd0, 5'd4, "R6");
    // R7
    apply(6'h09, 6'h00, 0, 16'hffff, 32'd10, 0, 5'd0, 5'd5, "R7");
    apply(6'h0c, 6'h00, 0, 16'hffff, 32'habcd_1234, 0, 5'd0, 5'd5, "R7");
    apply(6'h0d, 6'h00, 0, 16'h8000, 32'h0000_0001, 0, 5'd0, 5'd5, "R7");
    apply(6'h0e, 6'h00, 0, 16'hf0f0, 32'hffff_ffff, 0, 5'd0, 5'd5, "R7");
    // R8
    apply(6'h0f, 6'h00, 0, 16'hac51, 32'hffff_ffff, 0, 5'd0, 5'd17, "R8");
    // R9
    apply(6'h00, 6'h21, 0, 0, 32'd1, 32'd2, 5'd0, 5'd6, "R9");
    apply(6'h09, 6'h00, 0, 16'd3, 32'd1, 0, 5'd6, 5'd0, "R9");
    apply(6'h0d, 6'h00, 0, 16'd3, 32'd1, 0, 5'd0, 5'd21, "R9");
    // R10
    apply(6'h3f, 6'h00, 0, 16'h1234, 32'd1, 32'd2, 5'd3, 5'd4, "R10");
    apply(6'h00, 6'h01, 0, 0, 32'd1, 32'd2, 5'd3, 5'd4, "R10");
    apply(6'h00, 6'h18, 0, 0, 32'd1, 32'd2, 5'd3, 5'd4, "R10");

    // R11: outputs hold until the capturing edge
    @(negedge clk);
    op = 6'h0f; imm = 16'h5a5a; rt = 5'd9;
    #1;
    e_res = '0; e_we = 0; e_idx = 5'd3; e_trap = 0; e_ill = 1;
    compare("R11");
    model();
    @(negedge clk);
    compare("R11");

    // mixed stream
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [5:0] o, f;
      logic [31:0] a, b;
      logic [15:0] im;
      k = $urandom % 26;
      if (k < 16) begin o = 6'h00; f = fns[k]; end
      else if (k < 24) begin o = 6'(k - 8); f = 6'($urandom); end
      else begin o = ($urandom % 2) ? 6'h3f : 6'h00; f = 6'h3e; end
      a  = $urandom; b = $urandom; im = 16'($urandom);
      if ($urandom % 4 == 0) a = ($urandom % 2) ? 32'h7fff_ffff : 32'h8000_0000;
      if ($urandom % 4 == 0) b = ($urandom % 2) ? 32'h0000_0001 : 32'hffff_ffff;
      if ($urandom % 8 == 0) im = ($urandom % 2) ? 16'h7fff : 16'h8000;
      apply(o, f, 5'($urandom), im, a, b, 5'($urandom), 5'($urandom), tag_of(o, f));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule